// File: doc/BRIEF.md
# DMA Channel Control and Status Register

This block holds the status word of one DMA channel and turns software control writes into its run state. A single 32-bit control write carries a per-bit select in its upper half and the new bit values in its lower half. The block updates the run, pause and wake bits from that write and works out the active bit from them. When the channel stops, or when software asks for a flush, it hands the data mover a flush request. It commits the new status only after the mover acknowledges.

Hardware events feed in beside the software port. The sequencer reports a stop, a dead channel, a command fetch (which clears the wake bit) and the outcome of a branch test. Each time a committed status has the channel active, the block sends a one-cycle kick to the command sequencer. Reading the control address returns the status word.

Status bit positions: RUN 0, PAUSE 1, WAKE 2, FLUSH 3, ACTIVE 4, DEAD 5, BRANCH 6. All other bits read 0.

Top module: `chan_ctl_status`

## Requirements
- R1: A write is accepted when `wr_en` and `wr_ready` are both high. `wr_data[31:16]` selects bits and `wr_data[15:0]` gives their values. A status bit whose select is 0 keeps its value. Selects on ACTIVE (4), DEAD (5), BRANCH (6) and on unused bits have no effect.
- R2: Writing RUN (bit 0) as 1 under select sets RUN. Writing it as 0 under select clears both RUN and DEAD.
- R3: Writing WAKE (bit 2) as 1 under select sets WAKE only if RUN is 1 after the same write. A `cmd_fetch` pulse clears WAKE.
- R4: When PAUSE (bit 1) is selected, PAUSE takes the written value, whether that value is 0 or 1.
- R5: If PAUSE is 1 or RUN is 0 after the update, ACTIVE becomes 0. Otherwise ACTIVE becomes 1 when the write selected RUN or PAUSE, or wrote WAKE as 1. In every other case ACTIVE keeps its value.
- R6: Writing FLUSH (bit 3) as 1 under select raises `flush_req` from the next cycle. While the flush is pending, status shows FLUSH=1. `flush_req` stays high until `flush_ack` is seen. On that edge the new status commits, with FLUSH=0.
- R7: A write that leaves PAUSE=1 or RUN=0 also forces a flush, and its status commits only on `flush_ack`.
- R8: `kick` is high for exactly the one cycle in which a newly committed status (write or acknowledge) first shows ACTIVE=1.
- R9: While a flush is pending, `wr_ready` is 0 and `wr_en` is ignored. A `flush_ack` while nothing is pending has no effect.
- R10: `hw_stop` clears ACTIVE. `hw_dead` sets DEAD and clears ACTIVE. `bt_we` loads BRANCH from `bt_val`. These events apply on top of any write or commit in the same cycle.
- R11: `rd_data` returns the status word zero-extended to 32 bits.
- R12: After reset, status is 0, `flush_req`, `kick` are 0 and `wr_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Control write strobe |
| wr_data | input | 32 | Select in [31:16], values in [15:0] |
| wr_ready | output | 1 | Control write can be accepted |
| rd_data | output | 32 | Read of the control address (status word) |
| flush_req | output | 1 | Flush request to the data mover |
| flush_ack | input | 1 | Data mover finished flushing |
| hw_stop | input | 1 | Sequencer stop: drop ACTIVE |
| hw_dead | input | 1 | Sequencer fault: set DEAD, drop ACTIVE |
| cmd_fetch | input | 1 | Command fetched: clear WAKE |
| bt_we | input | 1 | Load the branch-taken bit |
| bt_val | input | 1 | Branch-taken value |
| status | output | 16 | Current status word |
| kick | output | 1 | One-cycle start pulse to the sequencer |

## Verification
The assertions assume the data mover only acknowledges in response to a request, and that the hardware event inputs never try to raise ACTIVE. Nothing but a software write can set that bit. The random stimulus respects this by construction. The hardware inputs can only stop the channel, kill it, clear WAKE or load the branch bit. Acknowledges come at random, both during and outside a flush, so stray acknowledges are covered as well. Writes select only the seven defined bits, plus random unused upper bits.

// File: rtl/chan_ctl_status.sv
module chan_ctl_status (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic        wr_ready,
  output logic [31:0] rd_data,
  output logic        flush_req,
  input  logic        flush_ack,
  input  logic        hw_stop,
  input  logic        hw_dead,
  input  logic        cmd_fetch,
  input  logic        bt_we,
  input  logic        bt_val,
  output logic [15:0] status,
  output logic        kick
);
  localparam int B_RUN = 0, B_PAUSE = 1, B_WAKE = 2, B_FLUSH = 3;
  localparam int B_ACTIVE = 4, B_DEAD = 5, B_BT = 6;

  logic [15:0] st_q, pend_q, nxt;
  logic        busy_q, kick_q;

  wire [15:0] msk = wr_data[31:16];
  wire [15:0] val = wr_data[15:0];
  wire unused_bits = &{1'b0, msk[15:7], val[15:7], msk[B_ACTIVE], msk[B_DEAD], msk[B_BT],
                       val[B_ACTIVE], val[B_DEAD], val[B_BT]};

  wire wr_go   = wr_en && !busy_q;
  wire wake_wr = msk[B_WAKE] && val[B_WAKE];
  wire fl_wr   = msk[B_FLUSH] && val[B_FLUSH];
  logic halt;

  always_comb begin
    nxt = st_q;
    if (msk[B_RUN]) begin
      nxt[B_RUN] = val[B_RUN];
      if (!val[B_RUN]) nxt[B_DEAD] = 1'b0;
    end
    if (msk[B_PAUSE]) nxt[B_PAUSE] = val[B_PAUSE];
    if (wake_wr && nxt[B_RUN]) nxt[B_WAKE] = 1'b1;
    halt = nxt[B_PAUSE] || !nxt[B_RUN];
    if (halt) nxt[B_ACTIVE] = 1'b0;
    else if (msk[B_RUN] || msk[B_PAUSE] || wake_wr) nxt[B_ACTIVE] = 1'b1;
    nxt[B_FLUSH] = 1'b0;
  end

  function automatic logic [15:0] hw_apply(input logic [15:0] s);
    logic [15:0] r;
    r = s;
    if (cmd_fetch) r[B_WAKE] = 1'b0;
    if (hw_stop) r[B_ACTIVE] = 1'b0;
    if (hw_dead) begin
      r[B_DEAD]   = 1'b1;
      r[B_ACTIVE] = 1'b0;
    end
    if (bt_we) r[B_BT] = bt_val;
    return r;
  endfunction

  wire [15:0] nxt_hw  = hw_apply(nxt);
  wire [15:0] pend_hw = hw_apply(pend_q);
  wire [15:0] st_hw   = hw_apply(st_q);
  wire [15:0] stf_hw  = hw_apply(st_q | (16'(fl_wr) << B_FLUSH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= '0;
      pend_q <= '0;
      busy_q <= 1'b0;
      kick_q <= 1'b0;
    end else begin
      kick_q <= 1'b0;
      if (wr_go && (halt || fl_wr)) begin
        busy_q <= 1'b1;
        pend_q <= nxt_hw;
        st_q   <= stf_hw;
      end else if (wr_go) begin
        st_q   <= nxt_hw;
        kick_q <= nxt_hw[B_ACTIVE];
      end else if (busy_q && flush_ack) begin
        busy_q <= 1'b0;
        st_q   <= pend_hw;
        kick_q <= pend_hw[B_ACTIVE];
      end else begin
        st_q <= st_hw;
        if (busy_q) pend_q <= pend_hw;
      end
    end
  end

  assign status    = st_q;
  assign rd_data   = {16'h0000, st_q};
  assign flush_req = busy_q;
  assign wr_ready  = !busy_q;
  assign kick      = kick_q;
endmodule

// File: rtl/chan_ctl_status_chk.sv
module chan_ctl_status_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        wr_ready,
  input logic        flush_req,
  input logic        flush_ack,
  input logic [15:0] status,
  input logic [31:0] rd_data,
  input logic        kick
);
  // R8: a kick only accompanies an active committed status
  a_r8_kick_active: assert property (@(posedge clk) disable iff (!rst_n)
    kick |-> status[4]);
  // R6: request held until acknowledged
  a_r6_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req && !flush_ack |=> flush_req);
  // R6: FLUSH visible only while a flush is pending
  a_r6_flush_vis: assert property (@(posedge clk) disable iff (!rst_n)
    status[3] |-> flush_req);
  // R7: a flush starts only from an accepted write
  a_r7_flush_src: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flush_req) |-> $past(wr_en && wr_ready));
  // R5: active implies running and not paused
  a_r5_active_ok: assert property (@(posedge clk) disable iff (!rst_n)
    status[4] |-> (status[0] && !status[1]));
  // R9: status frozen against writes while stalled
  a_r9_stall: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req && !flush_ack |=> $stable(status[2:0]) || !status[2]);
  // R11: read returns status
  a_r11_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data == {16'h0000, status});
endmodule

bind chan_ctl_status chan_ctl_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ready(wr_ready),
  .flush_req(flush_req), .flush_ack(flush_ack), .status(status),
  .rd_data(rd_data), .kick(kick)
);

// File: tb/chan_ctl_status_test.sv
module chan_ctl_status_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, flush_ack = 0, hw_stop = 0, hw_dead = 0, cmd_fetch = 0, bt_we = 0, bt_val = 0;
  logic [31:0] wr_data = '0;
  logic wr_ready, flush_req, kick;
  logic [31:0] rd_data;
  logic [15:0] status;

  chan_ctl_status uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_ready(wr_ready),
    .rd_data(rd_data), .flush_req(flush_req), .flush_ack(flush_ack), .hw_stop(hw_stop),
    .hw_dead(hw_dead), .cmd_fetch(cmd_fetch), .bt_we(bt_we), .bt_val(bt_val),
    .status(status), .kick(kick));

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  logic [15:0] e_st = '0, e_pend = '0;
  logic e_busy = 0, e_kick = 0;
  string tag = "R12";

  task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", t, act, exp);
    end
  endtask

  function automatic logic [15:0] m_hw(input logic [15:0] s, input logic st, input logic dd,
                                       input logic fe, input logic bw, input logic bv);
    logic [15:0] r = s;
    if (fe) r[2] = 0;
    if (st) r[4] = 0;
    if (dd) begin r[5] = 1; r[4] = 0; end
    if (bw) r[6] = bv;
    return r;
  endfunction

  function automatic logic [16:0] m_write(input logic [15:0] s, input logic [31:0] d);
    logic [15:0] m = d[31:16], v = d[15:0], r = s;
    logic wk, hl;
    if (m[0]) begin r[0] = v[0]; if (!v[0]) r[5] = 0; end
    if (m[1]) r[1] = v[1];
    wk = m[2] & v[2];
    if (wk && r[0]) r[2] = 1;
    hl = r[1] || !r[0];
    if (hl) r[4] = 0; else if (m[0] || m[1] || wk) r[4] = 1;
    r[3] = 0;
    return {hl | (m[3] & v[3]), r};
  endfunction

  task automatic step(input logic we, input logic [31:0] d, input logic ack, input logic st,
                      input logic dd, input logic fe, input logic bw, input logic bv);
    logic [16:0] w;
    chk(tag, {16'h0, status}, {16'h0, e_st});
    chk("R6", {31'h0, flush_req}, {31'h0, e_busy});
    chk("R8", {31'h0, kick}, {31'h0, e_kick});
    chk("R9", {31'h0, wr_ready}, {31'h0, !e_busy});
    chk("R11", rd_data, {16'h0, e_st});
    wr_en = we; wr_data = d; flush_ack = ack; hw_stop = st; hw_dead = dd;
    cmd_fetch = fe; bt_we = bw; bt_val = bv;
    e_kick = 0;
    w = m_write(e_st, d);
    if (we && !e_busy) begin
      if (w[16]) begin
        e_busy = 1;
        e_pend = m_hw(w[15:0], st, dd, fe, bw, bv);
        e_st = m_hw(e_st | (16'(d[19] & d[3]) << 3), st, dd, fe, bw, bv);
      end else begin
        e_st = m_hw(w[15:0], st, dd, fe, bw, bv);
        e_kick = e_st[4];
      end
    end else if (e_busy && ack) begin
      e_busy = 0;
      e_st = m_hw(e_pend, st, dd, fe, bw, bv);
      e_kick = e_st[4];
    end else begin
      e_st = m_hw(e_st, st, dd, fe, bw, bv);
      if (e_busy) e_pend = m_hw(e_pend, st, dd, fe, bw, bv);
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] d);
    step(1, d, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic idle(input logic ack);
    step(0, 0, ack, 0, 0, 0, 0, 0);
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    tag = "R12"; idle(0);
    tag = "R2";  wr(32'h0001_0001); idle(0);
    step(0, 0, 0, 0, 1, 0, 0, 0); wr(32'h0001_0000); idle(0); idle(1); idle(0);
    tag = "R3";  wr(32'h0004_0004); idle(1); wr(32'h0001_0001); wr(32'h0004_0004);
    step(0, 0, 0, 0, 0, 1, 0, 0); idle(0);
    tag = "R4";  wr(32'h0002_0002); idle(0); idle(1); wr(32'h0002_0000); idle(0);
    tag = "R5";  step(0, 0, 0, 1, 0, 0, 0, 0); wr(32'h0078_0070); wr(32'h0004_0004); idle(0);
    tag = "R7";  wr(32'h0001_0000); wr(32'h0001_0001); idle(0); idle(0); idle(1); idle(1);
    tag = "R6";  wr(32'h0001_0001); wr(32'h0008_0008); idle(0); idle(1); idle(0);
    tag = "R10"; step(0, 0, 0, 0, 0, 0, 1, 1); step(0, 0, 0, 0, 1, 0, 1, 0); idle(0);
    tag = "R1";
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] d;
      d = {$urandom(), 16'h0} | ($urandom() & 32'h0000_ffff);
      if ($urandom_range(3) != 0) d[31:16] = d[31:16] & 16'h007f;
      step($urandom_range(9) < 3, d, $urandom_range(9) < 3, $urandom_range(19) == 0,
           $urandom_range(29) == 0, $urandom_range(9) == 0, $urandom_range(9) == 0,
           1'($urandom()));
    end
    idle(1); idle(0);
    summary();
  end
endmodule